// File: doc/BRIEF.md
# Dual-Channel Mode Combination Validator

This block decides whether a requested pair of operating modes can run at the same time on a two-channel tone synthesizer. Each channel asks for one mode: single-tone, 2-, 4-, 8- or 16-level modulation, or linear sweep. It also gives a modulation type (amplitude, frequency or phase) and a flag that requests ramp-up/ramp-down (RU/RD) amplitude control. A shared selector names the pin group that carries the RU/RD control. The choices are no pins, the two upper profile pins, the top profile pin alone, or the three spare serial data pins.

Legality is not a range check on each channel. The pin group that carries the ramp control limits which modulation depths the two channels may use together. Some pin groups allow a depth on one channel only, and some allow it on both. A controller puts a request on the inputs and pulses `validate`. One clock later the block shows a legal flag, the code of the rule that was broken, and whether the synchronisation clock output must be on. These results stay unchanged until the next pulse.

Top module: `mode_combo_validator`

## Requirements
- R1: Mode codes are 0 single-tone, 1 two-level, 2 four-level, 3 eight-level, 4 sixteen-level, 5 linear sweep. Codes 6 and 7 are reserved. Type codes are 0 amplitude, 1 frequency, 2 phase, and 3 is reserved. A reserved mode or type on either channel gives rule code 1.
- R2: With neither channel requesting RU/RD, any mix of single-tone, two-level, four-level and sweep is legal (code 0), including four-level on both channels.
- R3: An eight- or sixteen-level channel paired with a channel that is not single-tone gives rule code 4, whatever the ramp settings.
- R4: RU/RD on one or both channels while both are single-tone is legal for every source except source 0. Source codes are 0 none, 1 upper profile pair, 2 top profile pin, 3 serial data pins.
- R5: With source 1 and RU/RD requested, the legal cases are these: every non-single-tone channel has RU/RD and runs sweep (one or both channels), or exactly one channel runs two-level with RU/RD and the other is single-tone. Any other case gives code 5.
- R6: With source 2 and RU/RD requested, the only legal non-tone case is one channel at eight-level with RU/RD while the other is single-tone. Any other case gives code 5.
- R7: With source 3 and RU/RD requested, two or four levels with RU/RD are legal on one channel or on both at the same depth. Eight or sixteen levels with RU/RD are legal on one channel only. A non-tone channel without RU/RD, or a different depth, gives code 5.
- R8: RU/RD on a non-single-tone channel of amplitude type gives code 3. Frequency and phase types combine with RU/RD.
- R9: RU/RD requested on either channel with source 0 gives code 2.
- R10: When several rules are broken, the lowest code is reported, and `legal` is high exactly when the code is 0.
- R11: `syncReq` is high when either channel is not single-tone.
- R12: The results update on the clock edge where `validate` is high and hold while it is low.
- R13: A synchronous reset sets `legal` to 0, `ruleCode` to 0 and `syncReq` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| validate | input | 1 | Capture strobe for a request |
| ch0Mode | input | 3 | Channel 0 mode code |
| ch0Type | input | 2 | Channel 0 modulation type |
| ch0Ru | input | 1 | Channel 0 RU/RD request |
| ch1Mode | input | 3 | Channel 1 mode code |
| ch1Type | input | 2 | Channel 1 modulation type |
| ch1Ru | input | 1 | Channel 1 RU/RD request |
| ruSrc | input | 2 | RU/RD pin group selector |
| legal | output | 1 | Request is allowed |
| ruleCode | output | 3 | Lowest broken rule, 0 if none |
| syncReq | output | 1 | Synchronisation clock must be on |

## Verification
The bench sweeps every combination of mode, type and ramp flag on both channels under all four ramp sources. That covers reserved codes, every depth pairing and every pin group, so each rule boundary is crossed from both sides, and the mixed cases show which rule wins. Directed steps change the inputs without a strobe, to show the results hold, and apply reset, to show the results clear.

// File: rtl/mcv_pkg.sv
package mcv_pkg;
  localparam int NUM_CH = 2;
  localparam int MODE_W = 3;
  localparam int TYPE_W = 2;
  localparam int SRC_W  = 2;
  localparam int RULE_W = 3;

  localparam logic [MODE_W-1:0] MODE_TONE  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_LVL2  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_LVL4  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_LVL8  = 3'd3;
  localparam logic [MODE_W-1:0] MODE_LVL16 = 3'd4;
  localparam logic [MODE_W-1:0] MODE_SWEEP = 3'd5;

  localparam logic [TYPE_W-1:0] TYPE_AMP = 2'd0;
  localparam logic [TYPE_W-1:0] TYPE_RSV = 2'd3;

  localparam logic [SRC_W-1:0] SRC_NONE   = 2'd0;
  localparam logic [SRC_W-1:0] SRC_PAIR   = 2'd1;
  localparam logic [SRC_W-1:0] SRC_TOP    = 2'd2;
  localparam logic [SRC_W-1:0] SRC_SERIAL = 2'd3;

  localparam logic [RULE_W-1:0] RULE_OK     = 3'd0;
  localparam logic [RULE_W-1:0] RULE_ENC    = 3'd1;
  localparam logic [RULE_W-1:0] RULE_NOSRC  = 3'd2;
  localparam logic [RULE_W-1:0] RULE_AMPRU  = 3'd3;
  localparam logic [RULE_W-1:0] RULE_DEPTH  = 3'd4;
  localparam logic [RULE_W-1:0] RULE_PINGRP = 3'd5;

  typedef struct packed {
    logic clear;
    logic capture;
  } mcvStrobe_t;

  // One non-tone channel with ramp control on the given pin group
  function automatic logic srcSingleOk(input logic [SRC_W-1:0] src,
                                       input logic [MODE_W-1:0] mode);
    case (src)
      SRC_PAIR:   srcSingleOk = (mode == MODE_LVL2) || (mode == MODE_SWEEP);
      SRC_TOP:    srcSingleOk = (mode == MODE_LVL8);
      SRC_SERIAL: srcSingleOk = (mode >= MODE_LVL2) && (mode <= MODE_LVL16);
      default:    srcSingleOk = 1'b0;
    endcase
  endfunction

  // Both channels non-tone in the same mode, both with ramp control
  function automatic logic srcDualOk(input logic [SRC_W-1:0] src,
                                     input logic [MODE_W-1:0] mode);
    case (src)
      SRC_PAIR:   srcDualOk = (mode == MODE_SWEEP);
      SRC_SERIAL: srcDualOk = (mode == MODE_LVL2) || (mode == MODE_LVL4);
      default:    srcDualOk = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mcv_ctrl.sv
module mcv_ctrl
  import mcv_pkg::*;
(
  input  logic       rst,
  input  logic       validate,
  output mcvStrobe_t strobe
);
  // Reset wins over a simultaneous capture (R13)
  always_comb begin
    strobe.clear   = rst;
    strobe.capture = validate && !rst;
  end
endmodule

// File: rtl/mcv_datapath.sv
module mcv_datapath
  import mcv_pkg::*;
(
  input  logic                           clk,
  input  mcvStrobe_t                     strobe,
  input  logic [NUM_CH-1:0][MODE_W-1:0]  chMode,
  input  logic [NUM_CH-1:0][TYPE_W-1:0]  chType,
  input  logic [NUM_CH-1:0]              chRu,
  input  logic [SRC_W-1:0]               ruSrc,
  output logic                           legal,
  output logic [RULE_W-1:0]              ruleCode,
  output logic                           syncReq
);
  logic [NUM_CH-1:0] isTone, isDeep, badEnc, ampRu, ruCovered;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign isTone[c]    = (chMode[c] == MODE_TONE);
    assign isDeep[c]    = (chMode[c] == MODE_LVL8) || (chMode[c] == MODE_LVL16);
    assign badEnc[c]    = (chMode[c] > MODE_SWEEP) || (chType[c] == TYPE_RSV);
    assign ampRu[c]     = !isTone[c] && (chType[c] == TYPE_AMP) && chRu[c];
    assign ruCovered[c] = isTone[c] || chRu[c];
  end

  logic [NUM_CH-1:0]  nonTone;
  logic               ruAny, bothActive, sameMode, depthClash, comboOk;
  logic [MODE_W-1:0]  activeMode;
  logic [RULE_W-1:0]  nextCode;

  always_comb begin
    nonTone    = ~isTone;
    ruAny      = |chRu;
    bothActive = &nonTone;
    sameMode   = (chMode[0] == chMode[1]);
    activeMode = isTone[0] ? chMode[1] : chMode[0];
    depthClash = (|isDeep) && bothActive;

    if (!(|nonTone))
      comboOk = 1'b1;
    else if (!(&ruCovered))
      comboOk = 1'b0;
    else if (bothActive)
      comboOk = sameMode && srcDualOk(ruSrc, activeMode);
    else
      comboOk = srcSingleOk(ruSrc, activeMode);

    // Lowest-numbered broken rule wins
    if (|badEnc)                     nextCode = RULE_ENC;
    else if (ruAny && ruSrc == SRC_NONE) nextCode = RULE_NOSRC;
    else if (|ampRu)                 nextCode = RULE_AMPRU;
    else if (depthClash)             nextCode = RULE_DEPTH;
    else if (ruAny && !comboOk)      nextCode = RULE_PINGRP;
    else                             nextCode = RULE_OK;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      legal    <= 1'b0;
      ruleCode <= RULE_OK;
      syncReq  <= 1'b0;
    end else if (strobe.capture) begin
      legal    <= (nextCode == RULE_OK);
      ruleCode <= nextCode;
      syncReq  <= |nonTone;
    end
  end
endmodule

// File: rtl/mode_combo_validator.sv
module mode_combo_validator
  import mcv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              validate,
  input  logic [MODE_W-1:0] ch0Mode,
  input  logic [TYPE_W-1:0] ch0Type,
  input  logic              ch0Ru,
  input  logic [MODE_W-1:0] ch1Mode,
  input  logic [TYPE_W-1:0] ch1Type,
  input  logic              ch1Ru,
  input  logic [SRC_W-1:0]  ruSrc,
  output logic              legal,
  output logic [RULE_W-1:0] ruleCode,
  output logic              syncReq
);
  mcvStrobe_t                    strobe;
  logic [NUM_CH-1:0][MODE_W-1:0] modeV;
  logic [NUM_CH-1:0][TYPE_W-1:0] typeV;
  logic [NUM_CH-1:0]             ruV;

  assign modeV = {ch1Mode, ch0Mode};
  assign typeV = {ch1Type, ch0Type};
  assign ruV   = {ch1Ru, ch0Ru};

  mcv_ctrl u_ctrl (
    .rst      (rst),
    .validate (validate),
    .strobe   (strobe)
  );

  mcv_datapath u_dp (
    .clk      (clk),
    .strobe   (strobe),
    .chMode   (modeV),
    .chType   (typeV),
    .chRu     (ruV),
    .ruSrc    (ruSrc),
    .legal    (legal),
    .ruleCode (ruleCode),
    .syncReq  (syncReq)
  );
endmodule

// File: rtl/mcv_checker.sv
module mcv_checker
  import mcv_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              validate,
  input logic [MODE_W-1:0] ch0Mode,
  input logic [MODE_W-1:0] ch1Mode,
  input logic              ch0Ru,
  input logic              ch1Ru,
  input logic [SRC_W-1:0]  ruSrc,
  input logic              legal,
  input logic [RULE_W-1:0] ruleCode,
  input logic              syncReq
);
  a_r13_reset_clears: assert property (@(posedge clk)
    rst |=> (!legal && ruleCode == RULE_OK && !syncReq));

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !validate |=> ($stable(legal) && $stable(ruleCode) && $stable(syncReq)));

  a_r10_legal_iff_zero: assert property (@(posedge clk) disable iff (rst)
    validate |=> (legal == (ruleCode == RULE_OK)));

  a_r11_sync_needed: assert property (@(posedge clk) disable iff (rst)
    (validate && (ch0Mode != MODE_TONE || ch1Mode != MODE_TONE)) |=> syncReq);

  a_r9_no_source: assert property (@(posedge clk) disable iff (rst)
    (validate && ruSrc == SRC_NONE && (ch0Ru || ch1Ru)) |=> !legal);

  a_r3_deep_pair: assert property (@(posedge clk) disable iff (rst)
    (validate && (ch0Mode == MODE_LVL8 || ch0Mode == MODE_LVL16)
       && ch1Mode != MODE_TONE) |=> !legal);
endmodule

bind mode_combo_validator mcv_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .validate (validate),
  .ch0Mode  (ch0Mode),
  .ch1Mode  (ch1Mode),
  .ch0Ru    (ch0Ru),
  .ch1Ru    (ch1Ru),
  .ruSrc    (ruSrc),
  .legal    (legal),
  .ruleCode (ruleCode),
  .syncReq  (syncReq)
);

// File: tb/mode_combo_validator_test.sv
`timescale 1ns/1ps
module mode_combo_validator_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       validate = 1'b0;
  logic [2:0] ch0Mode = '0, ch1Mode = '0;
  logic [1:0] ch0Type = '0, ch1Type = '0;
  logic       ch0Ru = 1'b0, ch1Ru = 1'b0;
  logic [1:0] ruSrc = '0;
  logic       legal, syncReq;
  logic [2:0] ruleCode;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mode_combo_validator uut (
    .clk(clk), .rst(rst), .validate(validate),
    .ch0Mode(ch0Mode), .ch0Type(ch0Type), .ch0Ru(ch0Ru),
    .ch1Mode(ch1Mode), .ch1Type(ch1Type), .ch1Ru(ch1Ru),
    .ruSrc(ruSrc), .legal(legal), .ruleCode(ruleCode), .syncReq(syncReq)
  );

  // Reference rule evaluation taken from the requirement list
  function automatic int refCode(int m0, int t0, int r0, int m1, int t1, int r1, int s);
    int  k;
    bit  both, covered, ok;
    if (m0 > 5 || m1 > 5 || t0 == 3 || t1 == 3) return 1;                 // R1
    if ((r0 || r1) && s == 0) return 2;                                   // R9
    if ((m0 != 0 && t0 == 0 && r0 != 0) || (m1 != 0 && t1 == 0 && r1 != 0)) return 3; // R8
    if (((m0 == 3 || m0 == 4) && m1 != 0) || ((m1 == 3 || m1 == 4) && m0 != 0)) return 4; // R3
    if (r0 == 0 && r1 == 0) return 0;                                     // R2
    if (m0 == 0 && m1 == 0) return 0;                                     // R4
    both    = (m0 != 0) && (m1 != 0);
    k       = (m0 != 0) ? m0 : m1;
    covered = (m0 == 0 || r0 != 0) && (m1 == 0 || r1 != 0);
    if (!covered) return 5;
    if (both && m0 != m1) return 5;
    case (s)
      1: ok = both ? (k == 5) : (k == 1 || k == 5);                        // R5
      2: ok = !both && k == 3;                                             // R6
      3: ok = both ? (k == 1 || k == 2) : (k >= 1 && k <= 4);              // R7
      default: ok = 0;
    endcase
    return ok ? 0 : 5;
  endfunction

  function automatic string tagFor(int code, int s, int r0, int r1);
    case (code)
      1: return "R1";
      2: return "R9";
      3: return "R8";
      4: return "R3";
      5: return (s == 1) ? "R5" : (s == 2) ? "R6" : "R7";
      default: return (r0 != 0 || r1 != 0) ? "R4" : "R2";
    endcase
  endfunction

  task automatic checkOut(string tag, int expLegal, int expCode, int expSync);
    vectors++;
    if (int'(legal) != expLegal || int'(ruleCode) != expCode || int'(syncReq) != expSync) begin
      fails++;
      $display("FAIL %s: legal/code/sync got %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, legal, ruleCode, syncReq, expLegal, expCode, expSync);
    end
  endtask

  task automatic apply(int m0, int t0, int r0, int m1, int t1, int r1, int s);
    ch0Mode = 3'(m0); ch0Type = 2'(t0); ch0Ru = 1'(r0);
    ch1Mode = 3'(m1); ch1Type = 2'(t1); ch1Ru = 1'(r1);
    ruSrc = 2'(s);
    validate = 1'b1;
    @(negedge clk);
    validate = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finishRun();
  end

  initial begin : main
    int c;
    repeat (3) @(negedge clk);
    // R13: reset state
    checkOut("R13 reset", 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);

    // Exhaustive sweep; cases breaking several rules check R10 priority
    for (int s = 0; s < 4; s++)
      for (int m0 = 0; m0 < 8; m0++)
        for (int t0 = 0; t0 < 4; t0++)
          for (int r0 = 0; r0 < 2; r0++)
            for (int m1 = 0; m1 < 8; m1++)
              for (int t1 = 0; t1 < 4; t1++)
                for (int r1 = 0; r1 < 2; r1++) begin
                  apply(m0, t0, r0, m1, t1, r1, s);
                  c = refCode(m0, t0, r0, m1, t1, r1, s);
                  checkOut(tagFor(c, s, r0, r1), (c == 0) ? 1 : 0, c,
                           (m0 != 0 || m1 != 0) ? 1 : 0);       // R11 in sync field
                end

    // R10: reserved mode plus ramp with no source and deep pairing -> code 1
    apply(6, 1, 1, 3, 0, 1, 0);
    checkOut("R10 priority", 0, 1, 1);

    // R12: a legal result holds while inputs change without a strobe
    apply(2, 1, 0, 2, 2, 0, 0);
    checkOut("R12 capture", 1, 0, 1);
    ch0Mode = 3'd4; ch1Mode = 3'd4; ch0Ru = 1'b1; ruSrc = 2'd0;
    repeat (3) @(negedge clk);
    checkOut("R12 hold", 1, 0, 1);

    // R13: reset clears a legal, sync-requiring result
    rst = 1'b1;
    @(negedge clk);
    checkOut("R13 clear", 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    finishRun();
  end
endmodule